// File: doc/BRIEF.md
# Parallel Flash Mode and Identification Controller

This block is the command-side mode logic in front of a parallel NOR flash array. It watches the active-low chip-enable, write-enable and output-enable strobes. It brings them into the internal clock domain and qualifies write cycles that have the right strobe combination and a long enough pulse. On each qualified write it acts on decoded command strobes that an upstream decoder supplies. It tracks which of four read modes the device is in: normal array read, erase-suspended array read, query, or identification.

In identification mode the read bus returns a manufacturer code, a device code held in a parameter, or a sector-protect status byte taken from a parameter map of protect bits. Identification can be entered by command, or by a high-voltage flag combined with specific strobe and address levels. Leaving identification returns the block to whichever array-read mode was active before it entered. A supply-good input holds the block in array read and locks out all writes while the supply is out of range. Reading the array contents, programming, erasing and analog voltage detection belong to other blocks.

Top module: `flash_mode_ctrl`

## Requirements
- R1: After reset, `modeOut` is 0, `dataOut` is 0 and `dataValid` is 0. The mode encoding is 0 = array read, 1 = erase-suspended array read, 2 = query, 3 = identification.
- R2: A write cycle counts only when `ceN` and `weN` are both low and `oeN` is high. A pulse with any other combination changes no mode.
- R3: A write pulse whose qualifying strobe combination is held for fewer than `MIN_W` clock cycles after synchronization is discarded. A pulse held for `MIN_W` or more cycles is accepted when it ends.
- R4: An identification command on an accepted write moves the block to identification from array read, erase-suspended read or query. The block then serves any number of identification reads without another entry command.
- R5: In identification, a read with `addr[1]`=0 returns 0xC2 when `addr[0]`=0 and `DEV_ID` when `addr[0]`=1. A read with `addr[1]`=1 returns 0x01 if bit s of `PROT_MAP` is set and 0x00 if it is clear, where s = `addr[ADDR_W-1 -: SEC_W]`.
- R6: A reset command in identification or query mode returns the block to the array-read mode recorded on entry, which is erase-suspended read if the block was suspended then. In array read or erase-suspended read, a reset command has no effect.
- R7: The block enters identification from either array-read mode when `hvPin` is high while `ceN`, `oeN`, `addr[6]` and `addr[1]` are low. When `hvPin` falls, it returns to the recorded array-read mode. With `addr[6]` high, no entry occurs.
- R8: While `supplyOk` is low, the block is forced to array read, clears its recorded prior mode and ignores writes.
- R9: `dataOut` is 0 and `dataValid` is 0 unless `ceN` and `oeN` are both low and the mode is identification.
- R10: A suspend command moves array read to erase-suspended read. A resume command moves erase-suspended read back to array read. A query command moves either array-read mode to query. When several command strobes are high in one write, priority is reset, then identification, then query, then suspend, then resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low asynchronous power-up reset |
| ceN | input | 1 | Chip enable, active low, asynchronous |
| weN | input | 1 | Write enable, active low, asynchronous |
| oeN | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Bus address |
| idCmd | input | 1 | Decoded identification-entry command |
| rstCmd | input | 1 | Decoded reset command |
| qryCmd | input | 1 | Decoded query-entry command |
| suspCmd | input | 1 | Decoded erase-suspend command |
| resumeCmd | input | 1 | Decoded erase-resume command |
| hvPin | input | 1 | High-voltage identification flag |
| supplyOk | input | 1 | Supply within operating range |
| modeOut | output | 2 | Current mode |
| dataOut | output | 8 | Read data |
| dataValid | output | 1 | Read data is driven |

## Verification
The assertions assume that the command strobes hold steady from before a write pulse until a few cycles after it ends, because the block samples them only on the cycle a write is accepted. They also assume that `hvPin` and `supplyOk` are already clean synchronous levels. The stimulus changes every input on the falling clock edge and keeps each command strobe high across its whole write pulse plus a settling gap. It raises `hvPin` only while a read is in progress and lowers it before the next write.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_SUSP  = 2'd1,
    MODE_QUERY = 2'd2,
    MODE_IDENT = 2'd3
  } mode_e;

  typedef struct packed {
    logic identOn;
    logic readOn;
  } dpCtl_t;

  localparam logic [7:0] MFR_CODE = 8'hC2;
endpackage

// File: rtl/fmc_ctrl.sv
module fmc_ctrl
  import fmc_pkg::*;
#(
  parameter int MIN_W = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   ceN,
  input  logic   weN,
  input  logic   oeN,
  input  logic   addrBit6,
  input  logic   addrBit1,
  input  logic   idCmd,
  input  logic   rstCmd,
  input  logic   qryCmd,
  input  logic   suspCmd,
  input  logic   resumeCmd,
  input  logic   hvPin,
  input  logic   supplyOk,
  output mode_e  mode,
  output dpCtl_t dpCtl
);
  localparam int CNT_W = $clog2(MIN_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_W);

  logic [1:0] ceSync, weSync, oeSync;
  logic ceS, weS, oeS;
  logic writeLow, readLow, wrAccept, hvEnter, hvExit;
  logic [CNT_W-1:0] lowCnt;
  logic priorSusp, hvMode;
  mode_e nextMode, restoreMode;
  logic nextPrior, nextHv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceSync <= 2'b11;
      weSync <= 2'b11;
      oeSync <= 2'b11;
    end else begin
      ceSync <= {ceSync[0], ceN};
      weSync <= {weSync[0], weN};
      oeSync <= {oeSync[0], oeN};
    end
  end

  assign ceS = ceSync[1];
  assign weS = weSync[1];
  assign oeS = oeSync[1];
  assign writeLow = !ceS && !weS && oeS;
  assign readLow  = !ceS && !oeS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      lowCnt <= '0;
    else if (!supplyOk || !writeLow) lowCnt <= '0;
    else if (lowCnt != CNT_MAX)      lowCnt <= lowCnt + 1'b1;
  end

  assign wrAccept = supplyOk && !writeLow && (lowCnt == CNT_MAX);
  assign hvEnter  = supplyOk && hvPin && !hvMode && readLow && !addrBit6 && !addrBit1 &&
                    (mode == MODE_ARRAY || mode == MODE_SUSP);
  assign hvExit   = hvMode && !hvPin;
  assign restoreMode = priorSusp ? MODE_SUSP : MODE_ARRAY;

  always_comb begin
    nextMode  = mode;
    nextPrior = priorSusp;
    nextHv    = hvMode;
    if (!supplyOk) begin
      nextMode  = MODE_ARRAY;
      nextPrior = 1'b0;
      nextHv    = 1'b0;
    end else if (hvExit) begin
      nextMode = restoreMode;
      nextHv   = 1'b0;
    end else if (wrAccept) begin
      if (rstCmd) begin
        if (mode == MODE_IDENT || mode == MODE_QUERY) nextMode = restoreMode;
        nextHv = 1'b0;
      end else if (idCmd) begin
        if (mode != MODE_IDENT) begin
          nextMode = MODE_IDENT;
          if (mode != MODE_QUERY) nextPrior = (mode == MODE_SUSP);
        end
      end else if (qryCmd) begin
        if (mode == MODE_ARRAY || mode == MODE_SUSP) begin
          nextMode  = MODE_QUERY;
          nextPrior = (mode == MODE_SUSP);
        end
      end else if (suspCmd) begin
        if (mode == MODE_ARRAY) nextMode = MODE_SUSP;
      end else if (resumeCmd) begin
        if (mode == MODE_SUSP) nextMode = MODE_ARRAY;
      end
    end else if (hvEnter) begin
      nextMode  = MODE_IDENT;
      nextPrior = (mode == MODE_SUSP);
      nextHv    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= MODE_ARRAY;
      priorSusp <= 1'b0;
      hvMode    <= 1'b0;
    end else begin
      mode      <= nextMode;
      priorSusp <= nextPrior;
      hvMode    <= nextHv;
    end
  end

  assign dpCtl.identOn = (mode == MODE_IDENT);
  assign dpCtl.readOn  = readLow;

  assert_supply_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (mode == MODE_ARRAY));

  assert_no_stray_change_R2: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && !wrAccept && !hvEnter && !hvExit) |=> $stable(mode));

  assert_ident_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && !hvExit && wrAccept && idCmd && !rstCmd) |=> (mode == MODE_IDENT));

  assert_hv_leave_R7: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && hvExit) |=> (mode != MODE_IDENT));

  assert_accept_after_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrAccept |-> $past(writeLow));
endmodule

// File: rtl/fmc_dp.sv
module fmc_dp
  import fmc_pkg::*;
#(
  parameter int SEC_W = 3,
  parameter logic [7:0] DEV_ID = 8'hBA,
  parameter logic [(1<<SEC_W)-1:0] PROT_MAP = '0
) (
  input  dpCtl_t           dpCtl,
  input  logic [SEC_W-1:0] sector,
  input  logic [1:0]       addrLow,
  output logic [7:0]       dataOut,
  output logic             dataValid
);
  logic protBit;
  assign protBit = PROT_MAP[sector];

  always_comb begin
    dataOut   = 8'h00;
    dataValid = 1'b0;
    if (dpCtl.readOn && dpCtl.identOn) begin
      dataValid = 1'b1;
      if (addrLow[1])      dataOut = {7'b0, protBit};
      else if (addrLow[0]) dataOut = DEV_ID;
      else                 dataOut = MFR_CODE;
    end
  end

  always_comb begin
    if (dataValid) begin
      assert_ident_byte_R5: assert (dataOut == MFR_CODE || dataOut == DEV_ID || dataOut[7:1] == 7'b0);
    end
  end
endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import fmc_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int SEC_W = 3,
  parameter int MIN_W = 3,
  parameter logic [7:0] DEV_ID = 8'hBA,
  parameter logic [(1<<SEC_W)-1:0] PROT_MAP = 8'b0010_0101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              idCmd,
  input  logic              rstCmd,
  input  logic              qryCmd,
  input  logic              suspCmd,
  input  logic              resumeCmd,
  input  logic              hvPin,
  input  logic              supplyOk,
  output logic [1:0]        modeOut,
  output logic [7:0]        dataOut,
  output logic              dataValid
);
  mode_e  mode;
  dpCtl_t dpCtl;
  logic   unusedAddr;

  assign unusedAddr = ^{addr[ADDR_W-SEC_W-1:7], addr[5:2]};

  fmc_ctrl #(.MIN_W(MIN_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addrBit6(addr[6]), .addrBit1(addr[1]),
    .idCmd(idCmd), .rstCmd(rstCmd), .qryCmd(qryCmd), .suspCmd(suspCmd),
    .resumeCmd(resumeCmd), .hvPin(hvPin), .supplyOk(supplyOk),
    .mode(mode), .dpCtl(dpCtl)
  );

  fmc_dp #(.SEC_W(SEC_W), .DEV_ID(DEV_ID), .PROT_MAP(PROT_MAP)) i_dp (
    .dpCtl(dpCtl), .sector(addr[ADDR_W-1 -: SEC_W]), .addrLow(addr[1:0]),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  assign modeOut = mode;
endmodule

// File: tb/test_flash_mode_ctrl.sv
module test_flash_mode_ctrl;
  localparam int ADDR_W = 18;
  localparam logic [7:0] DEV_ID = 8'hBA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic idCmd = 0, rstCmd = 0, qryCmd = 0, suspCmd = 0, resumeCmd = 0;
  logic hvPin = 0, supplyOk = 1;
  logic [1:0] modeOut;
  logic [7:0] dataOut;
  logic dataValid;
  int errors = 0, checks = 0, cycles = 0;

  always #4 clk = ~clk;

  flash_mode_ctrl i_flash_mode_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .idCmd(idCmd), .rstCmd(rstCmd), .qryCmd(qryCmd), .suspCmd(suspCmd),
    .resumeCmd(resumeCmd), .hvPin(hvPin), .supplyOk(supplyOk),
    .modeOut(modeOut), .dataOut(dataOut), .dataValid(dataValid)
  );

  // vector: cycles[13:10] ceN[9] weN[8] oeN[7] cmd{rst,id,qry,susp,resume}[6:2] expected mode[1:0]
  localparam logic [13:0] VEC [16] = '{
    {4'd3, 3'b001, 5'b01000, 2'd3},  // R4 id from array
    {4'd3, 3'b001, 5'b10000, 2'd0},  // R6 reset back to array
    {4'd2, 3'b001, 5'b01000, 2'd0},  // R3 short pulse
    {4'd3, 3'b101, 5'b01000, 2'd0},  // R2 chip enable high
    {4'd3, 3'b000, 5'b01000, 2'd0},  // R2 output enable low
    {4'd3, 3'b001, 5'b00010, 2'd1},  // R10 suspend
    {4'd3, 3'b001, 5'b01000, 2'd3},  // R4 id from suspended
    {4'd3, 3'b001, 5'b10000, 2'd1},  // R6 back to suspended
    {4'd3, 3'b001, 5'b00100, 2'd2},  // R10 query
    {4'd3, 3'b001, 5'b01000, 2'd3},  // R4 id from query
    {4'd3, 3'b001, 5'b10000, 2'd1},  // R6 prior kept through query
    {4'd3, 3'b001, 5'b00001, 2'd0},  // R10 resume
    {4'd3, 3'b001, 5'b10000, 2'd0},  // R6 reset in array no effect
    {4'd3, 3'b001, 5'b00110, 2'd2},  // R10 query beats suspend
    {4'd3, 3'b001, 5'b10000, 2'd0},  // R6
    {4'd4, 3'b001, 5'b11000, 2'd0}   // R10 reset beats id
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int n, input logic c, input logic w, input logic o, input logic [4:0] cmd);
    @(negedge clk);
    {rstCmd, idCmd, qryCmd, suspCmd, resumeCmd} = cmd;
    ceN = c; weN = w; oeN = o;
    repeat (n) @(negedge clk);
    ceN = 1; weN = 1; oeN = 1;
    repeat (5) @(negedge clk);
    {rstCmd, idCmd, qryCmd, suspCmd, resumeCmd} = 5'b0;
  endtask

  task automatic readAt(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    addr = a; ceN = 0; oeN = 0; weN = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic readEnd();
    ceN = 1; oeN = 1;
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mode", modeOut, 0);
    check("R1 data", dataOut, 0);
    check("R1 valid", dataValid, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      pulse(int'(VEC[i][13:10]), VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6:2]);
      check($sformatf("R2/R3/R4/R6/R10 vector %0d", i), modeOut, int'(VEC[i][1:0]));
    end

    // R5 identification reads, repeated without re-entry (R4)
    pulse(3, 0, 0, 1, 5'b01000);
    readAt('0);
    check("R5 manufacturer", dataOut, 8'hC2);
    check("R5 valid", dataValid, 1);
    readAt(18'd1);
    check("R5 device", dataOut, DEV_ID);
    readAt({3'd2, 15'd2});
    check("R5 protected sector", dataOut, 8'h01);
    readAt({3'd3, 15'd2});
    check("R5 open sector", dataOut, 8'h00);
    readAt('0);
    check("R4 repeated read", dataOut, 8'hC2);
    @(negedge clk); oeN = 1; repeat (4) @(negedge clk);
    check("R9 oe high data", dataOut, 0);
    check("R9 oe high valid", dataValid, 0);
    readEnd();
    pulse(3, 0, 0, 1, 5'b10000);
    readAt('0);
    check("R9 array read data", dataOut, 0);
    check("R9 array read valid", dataValid, 0);
    readEnd();

    // R7 high-voltage entry from array
    hvPin = 1;
    readAt('0);
    check("R7 hv entry mode", modeOut, 3);
    check("R7 hv manufacturer", dataOut, 8'hC2);
    addr = 18'd1; repeat (2) @(negedge clk);
    check("R7 hv device", dataOut, DEV_ID);
    hvPin = 0; repeat (3) @(negedge clk);
    check("R7 hv exit to array", modeOut, 0);
    readEnd();
    // R7 from suspended
    pulse(3, 0, 0, 1, 5'b00010);
    hvPin = 1;
    readAt('0);
    check("R7 hv entry from suspended", modeOut, 3);
    hvPin = 0; repeat (3) @(negedge clk);
    check("R7 hv exit to suspended", modeOut, 1);
    readEnd();
    pulse(3, 0, 0, 1, 5'b00001);
    // R7 blocked by addr[6]
    hvPin = 1;
    readAt(18'h40);
    check("R7 addr6 blocks", modeOut, 0);
    hvPin = 0;
    readEnd();

    // R8 supply loss
    pulse(3, 0, 0, 1, 5'b01000);
    supplyOk = 0; repeat (3) @(negedge clk);
    check("R8 forced array", modeOut, 0);
    pulse(3, 0, 0, 1, 5'b01000);
    check("R8 write ignored", modeOut, 0);
    supplyOk = 1; repeat (2) @(negedge clk);
    pulse(3, 0, 0, 1, 5'b00010);
    supplyOk = 0; repeat (3) @(negedge clk);
    supplyOk = 1; repeat (2) @(negedge clk);
    check("R8 suspended dropped", modeOut, 0);
    pulse(3, 0, 0, 1, 5'b01000);
    pulse(3, 0, 0, 1, 5'b10000);
    check("R8 prior cleared", modeOut, 0);

    // R3 boundary: exactly MIN_W accepted
    pulse(3, 0, 0, 1, 5'b00100);
    check("R3 minimum width accepted", modeOut, 2);
    pulse(1, 0, 0, 1, 5'b10000);
    check("R3 one cycle discarded", modeOut, 2);
    pulse(3, 0, 0, 1, 5'b10000);

    // R1 power-up reset again
    rstN = 0; repeat (2) @(negedge clk);
    check("R1 reset mode", modeOut, 0);
    rstN = 1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule